// File: doc/BRIEF.md
# Adaptive Delta Nibble Decoder

This block turns a stream of 4-bit adaptive differential codes into signed 16-bit samples. Every accepted code moves a predicted sample (the accumulator) by an odd multiple of one eighth of the current step size. The same code then rescales the step size through a fixed table of factors in 1/64 units. Both results are held within fixed limits.

Before each update, the block copies the old accumulator into a previous-sample register. A later interpolation stage can blend the two outputs. Codes arrive one per clock on a valid strobe, and the decoder keeps up at that rate without stalling. A synchronous restart puts the predictor back into its initial state.

Top module: `adnd_decoder`

## Requirements
- R1: Under asynchronous reset (rst_n low) and after a clock edge with restart high, the current and previous samples read 0 and the step size is 127. The first code that follows therefore uses step 127.
- R2: In the code, bit 3 is the sign and bits 2:0 are the magnitude m. An accepted code adds (2m+1)*step/8 to the accumulator, or subtracts it when bit 3 is 1.
- R3: The eighth-of-product term truncates toward zero for both signs. For example, code 0x8 from the initial state gives -15, not -16.
- R4: The accumulator saturates at +32767 and at -32768 and never wraps.
- R5: After each accepted code, the step becomes step*F/64, truncated. F is 57 for m = 0..3 and 77, 102, 128, 153 for m = 4, 5, 6, 7.
- R6: The step is clamped to the range 127 to 24576 after every update.
- R7: On each accepted code, the previous-sample output takes the accumulator value from before that update.
- R8: An accepted code shows on the outputs after the clock edge that samples it. Codes on consecutive cycles are each processed, with no stall.
- R9: While nibbleValid is low and restart is low, both outputs and the step size hold their values whatever the code input does.
- R10: When restart and nibbleValid are high together, restart wins and the code is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous return to the initial predictor state |
| nibbleValid | input | 1 | Strobe: nibbleCode is taken this cycle |
| nibbleCode | input | 4 | Sign-magnitude code, bit 3 is the sign |
| sampleNow | output | 16 | Current accumulator, signed |
| samplePrev | output | 16 | Accumulator before the latest update, signed |

## Verification
The assertions assume that restart and nibbleValid are known at every clock edge after reset, and that nibbleCode is known whenever nibbleValid is high. They also assume that only a restart or an accepted code may change the state. The stimulus drives all inputs from a defined value at the falling edge and never leaves them X. Sequences of codes are chosen to push the step size into both clamps and the accumulator into both saturation limits. A restart is also issued together with a valid code, so the priority rule is exercised under legal inputs.

// File: rtl/adnd_pkg.sv
package adnd_pkg;

  // Strobes and decoded fields handed from control to datapath.
  typedef struct packed {
    logic       clear;
    logic       advance;
    logic       negate;
    logic [2:0] magCode;
  } adnd_strobe_t;

  // Step rescale factor in 1/64 units, chosen by code magnitude.
  function automatic logic [7:0] adaptFactor(input logic [2:0] mag);
    logic [7:0] f;
    case (mag)
      3'd4:    f = 8'd77;
      3'd5:    f = 8'd102;
      3'd6:    f = 8'd128;
      3'd7:    f = 8'd153;
      default: f = 8'd57;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/adnd_ctrl.sv
module adnd_ctrl
  import adnd_pkg::*;
(
  input  logic         restart,
  input  logic         nibbleValid,
  input  logic [3:0]   nibbleCode,
  output adnd_strobe_t strobe
);

  always_comb begin
    strobe.clear   = restart;
    strobe.advance = nibbleValid & ~restart;
    strobe.negate  = nibbleCode[3];
    strobe.magCode = nibbleCode[2:0];
  end

endmodule

// File: rtl/adnd_predict.sv
module adnd_predict #(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 15
) (
  input  logic signed [SAMPLE_W-1:0] accCur,
  input  logic        [STEP_W-1:0]   stepCur,
  input  logic                       negate,
  input  logic        [2:0]          magCode,
  output logic signed [SAMPLE_W-1:0] accNext
);

  localparam int PROD_W  = STEP_W + 4;
  localparam int DELTA_W = STEP_W + 1;
  localparam int WIDE_W  = (SAMPLE_W > DELTA_W) ? SAMPLE_W : DELTA_W;
  localparam int SUM_W   = WIDE_W + 2;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic        [3:0]         oddMult;
  logic        [PROD_W-1:0]  magProd;
  logic        [DELTA_W-1:0] deltaMag;
  logic signed [SUM_W-1:0]   deltaPos;
  logic signed [SUM_W-1:0]   deltaSigned;
  logic signed [SUM_W-1:0]   accExt;
  logic signed [SUM_W-1:0]   sum;

  always_comb begin
    oddMult  = {magCode, 1'b1};
    magProd  = PROD_W'(oddMult) * PROD_W'(stepCur);
    // Shifting the magnitude before applying the sign truncates toward zero.
    deltaMag = DELTA_W'(magProd >> 3);
    deltaPos = {{(SUM_W - DELTA_W){1'b0}}, deltaMag};
    deltaSigned = negate ? -deltaPos : deltaPos;
    accExt   = {{(SUM_W - SAMPLE_W){accCur[SAMPLE_W-1]}}, accCur};
    sum      = accExt + deltaSigned;
    if (sum > SAT_HI)      accNext = SAT_HI[SAMPLE_W-1:0];
    else if (sum < SAT_LO) accNext = SAT_LO[SAMPLE_W-1:0];
    else                   accNext = sum[SAMPLE_W-1:0];
  end

endmodule

// File: rtl/adnd_stepadapt.sv
module adnd_stepadapt
  import adnd_pkg::*;
#(
  parameter int STEP_W   = 15,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input  logic [STEP_W-1:0] stepCur,
  input  logic [2:0]        magCode,
  output logic [STEP_W-1:0] stepNext
);

  localparam int SCALE_W = STEP_W + 8;
  localparam logic [SCALE_W-1:0] LIM_LO = SCALE_W'(STEP_MIN);
  localparam logic [SCALE_W-1:0] LIM_HI = SCALE_W'(STEP_MAX);

  logic [SCALE_W-1:0] scaled;
  logic [SCALE_W-1:0] shifted;
  logic [SCALE_W-1:0] bounded;

  always_comb begin
    scaled  = SCALE_W'(stepCur) * SCALE_W'(adaptFactor(magCode));
    shifted = scaled >> 6;
    if (shifted > LIM_HI)      bounded = LIM_HI;
    else if (shifted < LIM_LO) bounded = LIM_LO;
    else                       bounded = shifted;
    stepNext = STEP_W'(bounded);
  end

endmodule

// File: rtl/adnd_datapath.sv
module adnd_datapath
  import adnd_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int STEP_W    = 15,
  parameter int STEP_MIN  = 127,
  parameter int STEP_MAX  = 24576,
  parameter int STEP_INIT = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  adnd_strobe_t               strobe,
  output logic signed [SAMPLE_W-1:0] accOut,
  output logic signed [SAMPLE_W-1:0] prevOut,
  output logic        [STEP_W-1:0]   stepOut
);

  localparam logic [STEP_W-1:0] STEP_RST = STEP_W'(STEP_INIT);

  logic signed [SAMPLE_W-1:0] accQ, prevQ, accNext;
  logic        [STEP_W-1:0]   stepQ, stepNext;

  adnd_predict #(.SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W)) u_predict (
    .accCur  (accQ),
    .stepCur (stepQ),
    .negate  (strobe.negate),
    .magCode (strobe.magCode),
    .accNext (accNext)
  );

  adnd_stepadapt #(.STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_step (
    .stepCur  (stepQ),
    .magCode  (strobe.magCode),
    .stepNext (stepNext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accQ  <= '0;
      prevQ <= '0;
      stepQ <= STEP_RST;
    end else if (strobe.clear) begin
      accQ  <= '0;
      prevQ <= '0;
      stepQ <= STEP_RST;
    end else if (strobe.advance) begin
      prevQ <= accQ;
      accQ  <= accNext;
      stepQ <= stepNext;
    end
  end

  assign accOut  = accQ;
  assign prevOut = prevQ;
  assign stepOut = stepQ;

endmodule

// File: rtl/adnd_decoder.sv
module adnd_decoder
  import adnd_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int STEP_W    = 15,
  parameter int STEP_MIN  = 127,
  parameter int STEP_MAX  = 24576,
  parameter int STEP_INIT = 127
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  input  logic                       nibbleValid,
  input  logic [3:0]                 nibbleCode,
  output logic signed [SAMPLE_W-1:0] sampleNow,
  output logic signed [SAMPLE_W-1:0] samplePrev
);

  adnd_strobe_t            strobe;
  logic [STEP_W-1:0]       stepNow;

  adnd_ctrl u_ctrl (
    .restart     (restart),
    .nibbleValid (nibbleValid),
    .nibbleCode  (nibbleCode),
    .strobe      (strobe)
  );

  adnd_datapath #(
    .SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX), .STEP_INIT(STEP_INIT)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .accOut  (sampleNow),
    .prevOut (samplePrev),
    .stepOut (stepNow)
  );

endmodule

// File: rtl/adnd_decoder_chk.sv
module adnd_decoder_chk #(
  parameter int SAMPLE_W = 16,
  parameter int STEP_W   = 15,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       restart,
  input logic                       nibbleValid,
  input logic                       magHigh,
  input logic signed [SAMPLE_W-1:0] sampleNow,
  input logic signed [SAMPLE_W-1:0] samplePrev,
  input logic        [STEP_W-1:0]   stepNow
);

  localparam int CMP_W = SAMPLE_W + STEP_W + 4;

  logic              accepted;
  logic signed [SAMPLE_W:0] diff;
  logic [CMP_W-1:0]  absDiff;
  logic [CMP_W-1:0]  deltaCap;

  always_comb begin
    accepted = nibbleValid & ~restart;
    diff     = {sampleNow[SAMPLE_W-1], sampleNow} - {samplePrev[SAMPLE_W-1], samplePrev};
    absDiff  = (diff < 0) ? CMP_W'(-diff) : CMP_W'(diff);
    deltaCap = (CMP_W'(stepNow) * CMP_W'(15)) >> 3;
  end

  // R1 / R10: restart clears both outputs, even alongside a valid code
  p_restart_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (sampleNow == '0) && (samplePrev == '0));

  // R7: previous output takes the pre-update accumulator
  p_prev_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> samplePrev == $past(sampleNow));

  // R9: idle cycles change nothing
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nibbleValid && !restart) |=> $stable(sampleNow) && $stable(samplePrev) && $stable(stepNow));

  // R6: step stays inside its clamp range
  p_step_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stepNow >= STEP_W'(STEP_MIN)) && (stepNow <= STEP_W'(STEP_MAX)));

  // R2: one code moves the accumulator at most 15*step/8
  p_delta_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> absDiff <= $past(deltaCap));

  // R5: magnitudes 0..3 never grow the step
  p_step_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && !magHigh) |=> stepNow <= $past(stepNow));

  // R5: magnitudes 4..7 never shrink the step
  p_step_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && magHigh) |=> stepNow >= $past(stepNow));

endmodule

bind adnd_decoder adnd_decoder_chk #(
  .SAMPLE_W(SAMPLE_W), .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .nibbleValid (nibbleValid),
  .magHigh     (nibbleCode[2]),
  .sampleNow   (sampleNow),
  .samplePrev  (samplePrev),
  .stepNow     (stepNow)
);

// File: tb/sim_adnd_decoder.sv
`timescale 1ns/1ps
module sim_adnd_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic nibbleValid = 1'b0;
  logic [3:0] nibbleCode = 4'd0;
  logic signed [15:0] sampleNow, samplePrev;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int mAcc = 0, mPrev = 0, mStep = 127;

  // Hand-worked vectors from the initial state: {code, expected now, expected prev}
  localparam int VEC [8][3] = '{
    '{7,   238,    0}, '{7,   806,  238}, '{15, -551,  806}, '{8,  -767, -551},
    '{0,  -575, -767}, '{11, -1774, -575}, '{4,  -401, -1774}, '{0,  -218, -401}
  };

  always #2 clk = ~clk;

  adnd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .nibbleValid(nibbleValid),
    .nibbleCode(nibbleCode), .sampleNow(sampleNow), .samplePrev(samplePrev)
  );

  // Reference built from the requirement text
  function automatic void modelAdvance(input int code);
    int mag, d, f;
    mag = code & 7;
    d = ((2 * mag + 1) * mStep) / 8;
    if ((code & 8) != 0) d = -d;
    mPrev = mAcc;
    mAcc = mAcc + d;
    if (mAcc > 32767) mAcc = 32767;
    if (mAcc < -32768) mAcc = -32768;
    case (mag)
      4: f = 77;
      5: f = 102;
      6: f = 128;
      7: f = 153;
      default: f = 57;
    endcase
    mStep = (mStep * f) / 64;
    if (mStep > 24576) mStep = 24576;
    if (mStep < 127) mStep = 127;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic apply(input int code, input bit vld, input bit rs);
    nibbleCode = 4'(code);
    nibbleValid = vld;
    restart = rs;
    @(negedge clk);
    if (rs) begin
      mAcc = 0; mPrev = 0; mStep = 127;
    end else if (vld) begin
      modelAdvance(code);
    end
  endtask

  task automatic idle();
    nibbleValid = 1'b0;
    restart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset now", int'(sampleNow), 0);
    chk("R1 reset prev", int'(samplePrev), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 R7 R8: back-to-back table walk
    for (int i = 0; i < 8; i++) begin
      apply(VEC[i][0], 1'b1, 1'b0);
      chk("R8 table now", int'(sampleNow), VEC[i][1]);
      chk("R7 table prev", int'(samplePrev), VEC[i][2]);
    end

    // R9: idle with code wiggling
    for (int i = 0; i < 3; i++) apply(7 + i, 1'b0, 1'b0);
    chk("R9 hold now", int'(sampleNow), -218);
    chk("R9 hold prev", int'(samplePrev), -401);

    // R10: restart beats a concurrent valid code
    apply(7, 1'b1, 1'b1);
    chk("R10 restart now", int'(sampleNow), 0);
    chk("R10 restart prev", int'(samplePrev), 0);
    apply(7, 1'b1, 1'b0);
    chk("R1 step reloaded", int'(sampleNow), 238);

    // R3: negative truncation toward zero
    apply(0, 1'b0, 1'b1);
    apply(8, 1'b1, 1'b0);
    chk("R3 trunc toward zero", int'(sampleNow), -15);

    // R6: lower clamp (unclamped step would give 29)
    apply(0, 1'b0, 1'b1);
    apply(0, 1'b1, 1'b0);
    apply(0, 1'b1, 1'b0);
    chk("R6 min clamp", int'(sampleNow), 30);

    // R4 R6: drive to positive saturation and step ceiling
    apply(0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) apply(7, 1'b1, 1'b0);
    chk("R4 pos saturate", int'(sampleNow), 32767);
    apply(15, 1'b1, 1'b0);
    chk("R6 max clamp", int'(sampleNow), 32767 - 46080);
    for (int i = 0; i < 6; i++) apply(15, 1'b1, 1'b0);
    chk("R4 neg saturate", int'(sampleNow), -32768);
    chk("R7 prev at floor", int'(samplePrev), -32768);

    // R2 R5: pseudo-random stream against the reference
    begin
      logic [7:0] lfsr = 8'hA5;
      apply(0, 1'b0, 1'b1);
      for (int i = 0; i < 200; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        apply(int'(lfsr[3:0]), lfsr[6] | lfsr[1], 1'b0);
        chk("R2 R5 stream now", int'(sampleNow), mAcc);
        chk("R7 stream prev", int'(samplePrev), mPrev);
      end
    end
    idle();
    @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule